// File: doc/BRIEF.md
# Power-Fail Supervisor with Reset Stretch

This block watches two digital comparator outputs that report whether the main supply is above a fail threshold and above a switch threshold. From them it derives three controls. The first blocks every access to the clock registers and the memory. The second chooses between the main supply and the backup battery. The third is an active-low reset modelled as an open-drain line.

Both comparator inputs pass through a synchroniser and a debounce filter before any decision is made. A static strap says which threshold is the lower one. The switch to battery happens when the supply falls below that lower threshold. The return to the main supply waits until the supply is above both thresholds.

Reset is pulled low as soon as the filtered supply drops below the fail threshold. After the supply recovers, reset stays low for a fixed number of timer ticks. The ticks come from a free-running prescaler on the block's own clock, so no oscillator-enable control can stop them. If the supply dips during that stretch, the count starts again from zero.

Top module: `power_fail_supervisor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `access_block`, `use_battery` and `rst_drive_low` are all 1.
- R2: `access_block` equals the inverse of the filtered fail-threshold input. A settled change on `sup_above_fail` reaches `access_block` exactly SYNC_STAGES+DEBOUNCE+1 clock edges after it is applied, and not earlier.
- R3: A comparator level that holds for fewer than DEBOUNCE cycles has no effect on any output. A level that holds for exactly DEBOUNCE cycles is accepted.
- R4: With `fail_below_switch`=0 (fail threshold at or above the switch threshold), `use_battery` goes to 1 when the filtered `sup_above_switch` is 0. A drop of `sup_above_fail` alone leaves it unchanged.
- R5: With `fail_below_switch`=1 (fail threshold below the switch threshold), `use_battery` goes to 1 when the filtered `sup_above_fail` is 0.
- R6: `use_battery` returns to 0 only when both filtered comparator inputs are 1. In every other case it keeps its previous value, unless R4 or R5 sets it.
- R7: `rst_drive_low` is 1 in every cycle in which `access_block` is 1. It asserts on the same edge as `access_block`.
- R8: After the filtered fail-threshold input returns to 1, `rst_drive_low` stays 1 for exactly STRETCH_TICKS*PRESCALE clock edges and then goes to 0. From a settled raw rise, that is SYNC_STAGES+DEBOUNCE+STRETCH_TICKS*PRESCALE edges.
- R9: A filtered supply drop during the stretch clears the tick count. A full stretch is then timed again from the next recovery.
- R10: Once the supply is settled, `rst_drive_low` equals the inverse of `sup_above_fail`. A 1 means the line is pulled low and a 0 means the line is released; the line is never driven high.
- R11: STRETCH_TICKS*TICK_NS must lie within 40 ms to 200 ms inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock; also times the reset stretch |
| rst | input | 1 | Synchronous active-high reset |
| sup_above_fail | input | 1 | Asynchronous comparator output: supply above the fail threshold |
| sup_above_switch | input | 1 | Asynchronous comparator output: supply above the battery switch threshold |
| fail_below_switch | input | 1 | Static strap: 1 when the fail threshold is below the switch threshold |
| access_block | output | 1 | 1 blocks all clock-register and memory access |
| use_battery | output | 1 | 1 selects the backup battery, 0 selects the main supply |
| rst_drive_low | output | 1 | 1 pulls the open-drain reset line low, 0 releases it |

## Verification
A debounce counter that does not clear shows up as a short glitch reaching `access_block` about SYNC_STAGES+DEBOUNCE+1 cycles after the glitch. A filter that lets too much through does the same, in the same cycle. An off-by-one in the filter or output register moves the edge of `access_block` or `use_battery` one cycle away from the expected edge. A wrong supply-select state leaves `use_battery` at the wrong level after a transition between any two of the four comparator combinations. A bad tick count or prescaler phase moves the release of `rst_drive_low` away from its exact edge, one tick or more after recovery. A missing restart on a dip shows up as an early release.

// File: rtl/pfs_pkg.sv
package pfs_pkg;

    localparam longint STRETCH_MIN_NS = 64'd40_000_000;
    localparam longint STRETCH_MAX_NS = 64'd200_000_000;

    typedef struct packed {
        logic fail_ok;
        logic switch_ok;
    } supply_lv_t;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_BATT = 1'b1
    } supply_src_t;

    typedef enum logic [1:0] {
        RS_HOLD  = 2'd0,
        RS_COUNT = 2'd1,
        RS_RUN   = 2'd2
    } rst_state_t;

    function automatic logic lower_lost(supply_lv_t lv, logic fail_below_sw);
        return fail_below_sw ? !lv.fail_ok : !lv.switch_ok;
    endfunction

    function automatic logic all_ok(supply_lv_t lv);
        return lv.fail_ok && lv.switch_ok;
    endfunction

    function automatic bit stretch_in_window(longint ticks, longint tick_ns);
        return (ticks * tick_ns >= STRETCH_MIN_NS) && (ticks * tick_ns <= STRETCH_MAX_NS);
    endfunction

endpackage

// File: rtl/pfs_filter.sv
module pfs_filter #(
    parameter int N           = 2,
    parameter int SYNC_STAGES = 2,
    parameter int DEBOUNCE    = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw_in,
    output logic [N-1:0] clean_out
);
    localparam int CW = $clog2(DEBOUNCE) + 1;
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE - 1);

    for (genvar i = 0; i < N; i++) begin : g_ch
        logic [SYNC_STAGES-1:0] shr;
        logic [CW-1:0]          run;
        logic                   held;
        logic                   synced;

        assign synced = shr[SYNC_STAGES-1];

        always_ff @(posedge clk) begin
            if (rst) begin
                shr <= '0;
            end else begin
                shr <= {shr[SYNC_STAGES-2:0], raw_in[i]};
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                run  <= '0;
                held <= 1'b0;
            end else if (synced != held) begin
                if (run == LAST) begin
                    held <= synced;
                    run  <= '0;
                end else begin
                    run <= run + 1'b1;
                end
            end else begin
                run <= '0;
            end
        end

        assign clean_out[i] = held;
    end

endmodule

// File: rtl/pfs_supply_ctl.sv
module pfs_supply_ctl
    import pfs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  supply_lv_t lv,
    input  logic       fail_below_sw,
    output logic       blk_q,
    output logic       batt_q
);
    supply_src_t src, src_nx;

    always_comb begin
        src_nx = src;
        if (all_ok(lv)) begin
            src_nx = SRC_MAIN;
        end else if (lower_lost(lv, fail_below_sw)) begin
            src_nx = SRC_BATT;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src   <= SRC_BATT;
            blk_q <= 1'b1;
        end else begin
            src   <= src_nx;
            blk_q <= !lv.fail_ok;
        end
    end

    assign batt_q = (src == SRC_BATT);

endmodule

// File: rtl/pfs_rst_stretch.sv
module pfs_rst_stretch
    import pfs_pkg::*;
#(
    parameter int PRESCALE      = 1000,
    parameter int STRETCH_TICKS = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_ok,
    output logic pull_low
);
    localparam int PW = $clog2(PRESCALE) + 1;
    localparam int TW = $clog2(STRETCH_TICKS + 1) + 1;
    localparam logic [PW-1:0] P_LAST = PW'(PRESCALE - 1);
    localparam logic [TW-1:0] T_END  = TW'(STRETCH_TICKS);

    rst_state_t    st;
    logic [PW-1:0] presc;
    logic [TW-1:0] ticks;
    logic          tick;

    assign tick = (presc == P_LAST);

    always_ff @(posedge clk) begin
        if (rst || !fail_ok) begin
            st    <= RS_HOLD;
            presc <= '0;
            ticks <= '0;
        end else begin
            presc <= tick ? '0 : presc + 1'b1;
            case (st)
                RS_HOLD, RS_COUNT: begin
                    st <= RS_COUNT;
                    if (tick) begin
                        ticks <= ticks + 1'b1;
                        if (ticks + 1'b1 == T_END) begin
                            st <= RS_RUN;
                        end
                    end
                end
                default: st <= RS_RUN;
            endcase
        end
    end

    assign pull_low = (st != RS_RUN);

endmodule

// File: rtl/power_fail_supervisor.sv
module power_fail_supervisor
    import pfs_pkg::*;
#(
    parameter int     SYNC_STAGES   = 2,
    parameter int     DEBOUNCE      = 4,
    parameter int     PRESCALE      = 1000,
    parameter int     STRETCH_TICKS = 150,
    parameter longint TICK_NS       = 1_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic sup_above_fail,
    input  logic sup_above_switch,
    input  logic fail_below_switch,
    output logic access_block,
    output logic use_battery,
    output logic rst_drive_low
);
    logic [1:0] clean;
    supply_lv_t lv;

    pfs_filter #(
        .N(2),
        .SYNC_STAGES(SYNC_STAGES),
        .DEBOUNCE(DEBOUNCE)
    ) u_filt (
        .clk(clk),
        .rst(rst),
        .raw_in({sup_above_fail, sup_above_switch}),
        .clean_out(clean)
    );

    assign lv.fail_ok   = clean[1];
    assign lv.switch_ok = clean[0];

    pfs_supply_ctl u_ctl (
        .clk(clk),
        .rst(rst),
        .lv(lv),
        .fail_below_sw(fail_below_switch),
        .blk_q(access_block),
        .batt_q(use_battery)
    );

    pfs_rst_stretch #(
        .PRESCALE(PRESCALE),
        .STRETCH_TICKS(STRETCH_TICKS)
    ) u_rs (
        .clk(clk),
        .rst(rst),
        .fail_ok(lv.fail_ok),
        .pull_low(rst_drive_low)
    );

endmodule

// File: rtl/pfs_checker.sv
module pfs_checker
    import pfs_pkg::*;
#(
    parameter int     PRESCALE      = 1000,
    parameter int     STRETCH_TICKS = 150,
    parameter longint TICK_NS       = 1_000_000
) (
    input logic clk,
    input logic rst,
    input logic fail_ok_f,
    input logic switch_ok_f,
    input logic fail_below_switch,
    input logic access_block,
    input logic use_battery,
    input logic rst_drive_low
);
    localparam longint NEED = longint'(STRETCH_TICKS) * longint'(PRESCALE);

    logic [31:0] ok_run;

    always_ff @(posedge clk) begin
        if (rst || !fail_ok_f) begin
            ok_run <= '0;
        end else if (ok_run != 32'hFFFF_FFFF) begin
            ok_run <= ok_run + 1'b1;
        end
    end

    // R11
    initial begin
        stretch_window_chk: assert (stretch_in_window(longint'(STRETCH_TICKS), TICK_NS));
    end

    // R7
    block_implies_rst_chk: assert property (@(posedge clk) disable iff (rst)
        access_block |-> rst_drive_low);

    // R2
    block_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(access_block) |-> $past(!fail_ok_f));

    // R2
    block_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(access_block) |-> $past(fail_ok_f));

    // R4 R5
    batt_switch_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(use_battery) |-> $past(fail_below_switch ? !fail_ok_f : !switch_ok_f));

    // R6
    batt_return_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(use_battery) |-> $past(fail_ok_f && switch_ok_f));

    // R8
    stretch_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_drive_low) |-> (longint'(ok_run) >= NEED));

    // R10
    rst_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fail_ok_f |=> rst_drive_low);

endmodule

bind power_fail_supervisor pfs_checker #(
    .PRESCALE(PRESCALE),
    .STRETCH_TICKS(STRETCH_TICKS),
    .TICK_NS(TICK_NS)
) u_chk (
    .clk(clk),
    .rst(rst),
    .fail_ok_f(lv.fail_ok),
    .switch_ok_f(lv.switch_ok),
    .fail_below_switch(fail_below_switch),
    .access_block(access_block),
    .use_battery(use_battery),
    .rst_drive_low(rst_drive_low)
);

// File: tb/sim_power_fail_supervisor.sv
module sim_power_fail_supervisor;
    localparam int     SYNC    = 2;
    localparam int     DEB     = 4;
    localparam int     PRE     = 4;
    localparam int     STR     = 10;
    localparam longint TNS     = 5_000_000;
    localparam int     LAT     = SYNC + DEB + 1;
    localparam int     RELEASE = SYNC + DEB + STR * PRE;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pf = 1'b0, sw = 1'b0, cfg = 1'b0;
    logic blk, batt, rlow;
    int   checks = 0, fails = 0;
    bit   done = 1'b0;
    logic exp_batt;

    always #2 clk = ~clk;

    power_fail_supervisor #(
        .SYNC_STAGES(SYNC), .DEBOUNCE(DEB), .PRESCALE(PRE),
        .STRETCH_TICKS(STR), .TICK_NS(TNS)
    ) u0 (
        .clk(clk), .rst(rst), .sup_above_fail(pf), .sup_above_switch(sw),
        .fail_below_switch(cfg), .access_block(blk), .use_battery(batt),
        .rst_drive_low(rlow)
    );

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic edges(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    function automatic logic nb(logic prev, logic p, logic s, logic c);
        if (p && s) return 1'b0;
        if (c ? !p : !s) return 1'b1;
        return prev;
    endfunction

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        #(4 * 150_000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            report();
            $finish;
        end
    end

    initial begin
        edges(3);
        check("R1 blk in reset", blk, 1'b1);
        check("R1 batt in reset", batt, 1'b1);
        check("R1 rst in reset", rlow, 1'b1);
        rst = 1'b0;
        edges(1);
        check("R1 blk after reset", blk, 1'b1);
        check("R1 batt after reset", batt, 1'b1);
        check("R1 rst after reset", rlow, 1'b1);

        for (int c = 0; c < 2; c++) begin
            pf = 1'b0; sw = 1'b0;
            edges(60);
            cfg = c[0];
            exp_batt = 1'b1;
            edges(2);
            for (int f = 0; f < 4; f++) begin
                for (int t = 0; t < 4; t++) begin
                    string btag;
                    logic  pb;
                    pf = f[1]; sw = f[0];
                    exp_batt = nb(exp_batt, f[1], f[0], c[0]);
                    edges(60);
                    btag = (c == 0) ? "R4 settled batt" : "R5 settled batt";
                    check("R2 settled blk", blk, !f[1]);
                    check(btag, batt, exp_batt);
                    check("R10 settled rst", rlow, !f[1]);
                    pb = exp_batt;
                    pf = t[1]; sw = t[0];
                    exp_batt = nb(exp_batt, t[1], t[0], c[0]);
                    edges(LAT - 1);
                    check("R2 blk early", blk, !f[1]);
                    check("R6 batt early", batt, pb);
                    edges(1);
                    check("R2 blk edge", blk, !t[1]);
                    check(t == 3 ? "R6 batt edge" : btag, batt, exp_batt);
                    check("R7 rst edge", rlow, !(f[1] && t[1]));
                end
            end
        end

        cfg = 1'b0;
        pf = 1'b0; sw = 1'b0;
        edges(60);
        pf = 1'b1; sw = 1'b1;
        edges(RELEASE - 1);
        check("R8 rst before release", rlow, 1'b1);
        edges(1);
        check("R8 rst at release", rlow, 1'b0);

        pf = 1'b0;
        edges(60);
        pf = 1'b1;
        edges(20);
        check("R9 rst mid stretch", rlow, 1'b1);
        pf = 1'b0;
        edges(8);
        pf = 1'b1;
        edges(RELEASE - 1);
        check("R9 rst restarted", rlow, 1'b1);
        edges(1);
        check("R9 rst release after restart", rlow, 1'b0);

        edges(10);
        pf = 1'b0;
        edges(DEB - 1);
        pf = 1'b1;
        for (int k = 0; k < 20; k++) begin
            edges(1);
            check("R3 short fail glitch blk", blk, 1'b0);
            check("R3 short fail glitch rst", rlow, 1'b0);
        end
        sw = 1'b0;
        edges(DEB - 1);
        sw = 1'b1;
        for (int k = 0; k < 20; k++) begin
            edges(1);
            check("R3 short switch glitch batt", batt, 1'b0);
        end
        pf = 1'b0;
        edges(DEB);
        pf = 1'b1;
        edges(LAT - DEB);
        check("R3 full-length pulse blk", blk, 1'b1);
        check("R4 fail drop keeps main", batt, 1'b0);
        edges(60);
        check("R10 recovered rst", rlow, 1'b0);
        check("R2 recovered blk", blk, 1'b0);

        done = 1'b1;
        report();
        $finish;
    end

endmodule